// File: doc/BRIEF.md
# Two-Way Interleaved Multiply-Accumulate Stage

This block puts a combinational multiply-accumulate, `y = a * b + c`, into a pipeline that takes a new operand set on every clock, although the arithmetic needs more than one clock period to settle. The block does not cut the arithmetic with pipeline registers. It builds two identical copies of the datapath and hands operands to them in turn. A one-bit controller flips on every cycle. The copy whose turn it is captures the operands when they are valid, and it then holds them untouched through the following cycle. Each copy therefore has two full clock periods to produce its result.

The same controller bit drives a two-way output multiplexer. The multiplexer forwards the copy that is in its second settling cycle. The timing budget for the slow path is the copy's delay plus the multiplexer delay, and it must fit within two clock periods. The result is presented combinationally from the held operands, so the stage downstream registers `out_y` at the end of the cycle in which `out_valid` is high.

The stream interface is plain valid/data with no ready signal. The block applies no back-pressure, and the consumer must accept a result in every cycle that `out_valid` is high. Reset is synchronous and active high.

Top module: `ilv_mac_stage`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid` is 0.
- R2: Each result is the unsigned value `in_a * in_b + in_c`, computed at full width, with the width of `out_y` equal to 2*DW+1 bits. This holds even at the all-ones operand corner.
- R3: `out_valid` is high in the cycle exactly two clock cycles after a cycle in which `in_valid` was high, and it is low otherwise.
- R4: A back-to-back stream with `in_valid` high on every cycle yields one correct result per cycle, in input order.
- R5: The turn bit flips on every cycle whether or not an input is valid, and it is 0 in the first cycle after reset. A copy loads only on its own turn, never loads on two consecutive cycles, and holds its operands for the cycle after it loads. If valid inputs arrive only on alternate cycles, they all land in the same copy and every result is still correct.
- R6: Asserting reset in the middle of a stream discards every operand in flight. No result appears for the operands accepted before the reset, and the stream restarts cleanly afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set on `in_a`, `in_b`, `in_c` is valid this cycle |
| in_a | input | DW | Multiplicand (unsigned) |
| in_b | input | DW | Multiplier (unsigned) |
| in_c | input | 2*DW | Addend (unsigned) |
| out_valid | output | 1 | `out_y` carries a result this cycle |
| out_y | output | 2*DW+1 | Result `a*b+c` of the operands accepted two cycles earlier |

## Verification
A back-to-back stream of random operands keeps both copies busy at once and exposes any mismatch between the turn bit and the multiplexer select. An every-other-cycle stream sends every operand to one copy. This separates a controller that flips every cycle from one that flips only on valid inputs. A random sparse pattern with idle gaps checks that `out_valid` follows `in_valid` exactly two cycles later, with no missing and no spurious results. Directed all-ones and zero operands check the full-width carry. A reset in mid-stream shows that in-flight operands are dropped.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic {
    LANE_EVEN = 1'b0,
    LANE_ODD  = 1'b1
  } lane_sel_e;
endpackage

// File: rtl/ilv_turn_ctrl.sv
module ilv_turn_ctrl
  import ilv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic [NUM_LANES-1:0] lane_load,
  output lane_sel_e            mux_sel,
  output logic                 out_valid
);
  lane_sel_e turn_q;
  logic [1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q <= LANE_EVEN;
      vld_q  <= '0;
    end else begin
      turn_q <= (turn_q == LANE_EVEN) ? LANE_ODD : LANE_EVEN;
      vld_q  <= {vld_q[0], in_valid};
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_load
    assign lane_load[i] = in_valid && (turn_q == lane_sel_e'(i));
  end

  // The lane loaded two edges ago had the same turn value it has now.
  assign mux_sel   = turn_q;
  assign out_valid = vld_q[1];

  // R5: the turn bit alternates on every cycle after reset
  assert_turn_flips_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (turn_q != $past(turn_q)));
endmodule

// File: rtl/ilv_mac_lane.sv
module ilv_mac_lane #(
  parameter int DW = 16,
  localparam int CW = 2 * DW,
  localparam int YW = 2 * DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] c,
  output logic [YW-1:0] y
);
  logic [DW-1:0] a_q, b_q;
  logic [CW-1:0] c_q;
  logic [CW-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (load) begin
      a_q <= a;
      b_q <= b;
      c_q <= c;
    end
  end

  // Multicycle path: settles within two clock periods of a load.
  assign prod = a_q * b_q;
  assign y    = {1'b0, prod} + {1'b0, c_q};

  // R5: a lane is never handed operands on two consecutive cycles
  assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

  // R5: held operands stay put through the second settling cycle
  assert_operands_held_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> ##2 ($stable(a_q) && $stable(b_q) && $stable(c_q)));
endmodule

// File: rtl/ilv_out_mux.sv
module ilv_out_mux
  import ilv_pkg::*;
#(
  parameter int YW = 33
) (
  input  lane_sel_e            sel,
  input  logic [NUM_LANES-1:0][YW-1:0] lane_y,
  output logic [YW-1:0]        y
);
  always_comb begin
    y = lane_y[0];
    for (int i = 0; i < NUM_LANES; i++) begin
      if (sel == lane_sel_e'(i)) y = lane_y[i];
    end
  end
endmodule

// File: rtl/ilv_mac_stage.sv
module ilv_mac_stage
  import ilv_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = 2 * DW,
  localparam int YW = 2 * DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [CW-1:0] in_c,
  output logic          out_valid,
  output logic [YW-1:0] out_y
);
  logic [NUM_LANES-1:0]         lane_load;
  logic [NUM_LANES-1:0][YW-1:0] lane_y;
  lane_sel_e                    mux_sel;

  ilv_turn_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lane_load (lane_load),
    .mux_sel   (mux_sel),
    .out_valid (out_valid)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    ilv_mac_lane #(.DW(DW)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .load (lane_load[i]),
      .a    (in_a),
      .b    (in_b),
      .c    (in_c),
      .y    (lane_y[i])
    );
  end

  ilv_out_mux #(.YW(YW)) u_mux (
    .sel    (mux_sel),
    .lane_y (lane_y),
    .y      (out_y)
  );

  // R5: at most one lane captures operands per cycle
  assert_single_load_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_load));

  // R3: every accepted operand yields a result two cycles later
  assert_result_due_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R3: no result without an operand two cycles earlier
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R1: nothing emerges in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/sim_ilv_mac_stage.sv
`timescale 1ns/100ps
module sim_ilv_mac_stage;
  localparam int DW = 16;
  localparam int CW = 2 * DW;
  localparam int YW = 2 * DW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic [CW-1:0] in_c = '0;
  logic          out_valid;
  logic [YW-1:0] out_y;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic          hv [4];
  logic [YW-1:0] hy [4];

  always #2.5 clk = ~clk;

  ilv_mac_stage #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_c(in_c), .out_valid(out_valid), .out_y(out_y)
  );

  function automatic logic [YW-1:0] ref_mac(logic [DW-1:0] a, logic [DW-1:0] b,
                                            logic [CW-1:0] c);
    logic [YW-1:0] wa, wb, wc;
    wa = YW'(a);
    wb = YW'(b);
    wc = YW'(c);
    return wa * wb + wc;
  endfunction

  task automatic chk(string tag, logic [YW-1:0] act, logic [YW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) begin
      hv[i] = 1'b0;
      hy[i] = '0;
    end
    n = 0;
  endtask

  // At a falling edge: check the result due now, then drive the next input.
  task automatic step(string tag, logic v, logic [DW-1:0] a, logic [DW-1:0] b,
                      logic [CW-1:0] c);
    logic ev;
    @(negedge clk);
    ev = (n >= 2) ? hv[(n - 2) % 4] : 1'b0;
    chk({tag, " valid (R3)"}, YW'(out_valid), YW'(ev));
    if (ev) chk({tag, " data"}, out_y, hy[(n - 2) % 4]);
    in_valid = v;
    in_a = a;
    in_b = b;
    in_c = c;
    hv[n % 4] = v;
    hy[n % 4] = ref_mac(a, b, c);
    n++;
  endtask

  task automatic rnd_step(string tag, logic v);
    step(tag, v, DW'($urandom), DW'($urandom), CW'($urandom));
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    clear_hist();
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", YW'(out_valid), '0);
    rst = 1'b0;

    // R1: first cycle after reset is quiet (checked inside first step)
    step("R1", 1'b0, '0, '0, '0);
    step("R1", 1'b0, '0, '0, '0);

    // R2: directed corners, all-ones carry and zeros
    step("R2", 1'b1, '1, '1, '1);
    step("R2", 1'b1, '0, '0, '0);
    step("R2", 1'b1, '1, '0, '1);
    step("R2", 1'b1, DW'(1), '1, CW'(1));
    step("R2", 1'b0, '0, '0, '0);
    step("R2", 1'b0, '0, '0, '0);

    // R4: back-to-back random stream
    for (int i = 0; i < 200; i++) rnd_step("R4", 1'b1);

    // R5: every other cycle, all operands land in one copy
    for (int i = 0; i < 60; i++) rnd_step("R5", (i % 2) == 0);
    for (int i = 0; i < 60; i++) rnd_step("R5", (i % 2) == 1);

    // R3: sparse random valid pattern with idle gaps
    for (int i = 0; i < 300; i++) rnd_step("R3", ($urandom % 3) == 0);
    rnd_step("R3", 1'b0);
    rnd_step("R3", 1'b0);

    // R6: reset in mid-stream drops in-flight operands
    for (int i = 0; i < 5; i++) rnd_step("R6", 1'b1);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R6 out_valid in reset", YW'(out_valid), '0);
    rst = 1'b0;
    in_valid = 1'b0;
    clear_hist();
    step("R6", 1'b0, '0, '0, '0);
    step("R6", 1'b0, '0, '0, '0);
    step("R6", 1'b0, '0, '0, '0);
    for (int i = 0; i < 20; i++) rnd_step("R6 recovery", 1'b1);
    rnd_step("R6 recovery", 1'b0);
    rnd_step("R6 recovery", 1'b0);
    rnd_step("R6 recovery", 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule